// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. It receives eight product terms from the AND array and combines them in an OR gate. It then drives a device pin, a tristate enable for that pin and a feedback line back into the AND array. Static configuration inputs set the cell's mode:

- a two-bit architecture code shared by every cell of the device;
- a per-cell mode bit;
- a per-cell polarity bit.

The modes are a clocked registered output, combinatorial I/O in both registered and register-free devices, a dedicated combinatorial output, and a dedicated input.

The mode changes three things together. It sets how many product terms reach the OR gate. It selects what enables the pin driver. It picks where the feedback line is taken from. In the I/O modes the last product term leaves the sum and becomes the pin enable.

A parameter places the cell in the device: an interior cell, the end cell that borrows the clock pin, the end cell that borrows the enable pin, or a middle cell with no feedback in dedicated-output mode. In register-free devices the two end cells take that borrowed pin's level, supplied on `endPinIn`, as their feedback.

Top module: `sop_out_cell`

## Requirements
- R1: With `cfgArch`=2'b10 and `cfgCell`=0 (registered mode), the register captures (OR of all eight terms) XOR `cfgInvert` on each rising clock edge, and `pinOut` shows the register.
- R2: In registered mode, `pinOe` equals the inverse of the active-low `oeN`, and `fbOut` equals the register value.
- R3: `cfgInvert`=1 inverts the OR result before it reaches the pin in every combinatorial mode.
- R4: With `cfgCell`=1 and `cfgArch` 2'b10 or 2'b11 (combinatorial I/O), `pinOut` is (OR of terms 0..6) XOR `cfgInvert`. Term 7 has no effect on `pinOut`, and `pinOe` equals term 7.
- R5: In combinatorial I/O mode, `fbOut` equals `pinIn`, except as stated in R8.
- R6: With `cfgArch`=2'b01 and `cfgCell`=0 (dedicated output), `pinOut` is (OR of all eight terms) XOR `cfgInvert` and `pinOe` is 1. `fbOut` depends on the cell position: an interior cell takes `adjPinIn`, and a no-feedback middle cell gives 0.
- R7: With `cfgArch`=2'b01 and `cfgCell`=1 (dedicated input), `pinOe` is 0, and interior and middle cells give `adjPinIn` on `fbOut`.
- R8: When `cfgArch` bit 0 is 1 (register-free device), both end-cell kinds give `endPinIn` on `fbOut` in every defined mode.
- R9: Undefined codes (`cfgArch`=2'b00, or `cfgArch`=2'b11 with `cfgCell`=0) give `pinOe`=0 and `fbOut`=0.
- R10: `rstN` low at a rising edge clears the register to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| rstN | input | 1 | Synchronous active-low register clear |
| termIn | input | N_TERMS | Product terms from the AND array; the top index is the enable term |
| cfgArch | input | 2 | Device-wide architecture code |
| cfgCell | input | 1 | Per-cell mode bit |
| cfgInvert | input | 1 | Per-cell polarity: 1 inverts the OR result |
| oeN | input | 1 | Device-wide pin enable, active low |
| pinIn | input | 1 | Level observed on this cell's pin |
| adjPinIn | input | 1 | Level observed on the neighbouring cell's pin |
| endPinIn | input | 1 | Level of the borrowed clock or enable pin (end cells) |
| pinOut | output | 1 | Value for the pin driver |
| pinOe | output | 1 | Pin driver enable |
| fbOut | output | 1 | Feedback to the AND array |

## Verification
All outputs except the registered value follow their inputs within the same cycle. The registered value follows the terms and polarity present at a rising edge, and is visible from that edge on. The bench drives new stimulus 1 ns after each rising edge and advances its reference register at the rising edge, using the inputs held at that moment. It compares all outputs of four cell-position instances at the following falling edge. After a reset cycle, the registered output is compared against 0, and each comparison is tagged with the requirement that produced its expected value.

// File: rtl/sop_cell_pkg.sv
`timescale 1ns/1ps
package sop_cell_pkg;

  typedef enum logic [1:0] {
    CELL_INNER,
    CELL_CLK_END,
    CELL_OE_END,
    CELL_NOFB
  } cellKind_e;

  typedef enum logic [2:0] {
    M_REG,
    M_IO_REGDEV,
    M_IO_COMB,
    M_OUT_COMB,
    M_IN,
    M_BAD
  } cellMode_e;

  typedef enum logic [1:0] {
    OE_GLOBAL,
    OE_TERM,
    OE_ON,
    OE_OFF
  } oeSrc_e;

  typedef enum logic [2:0] {
    FB_REG,
    FB_OWN,
    FB_ADJ,
    FB_END,
    FB_ZERO
  } fbSrc_e;

  typedef struct packed {
    logic   useReg;
    logic   dropLast;
    oeSrc_e oeSrc;
    fbSrc_e fbSrc;
  } cellStrobe_t;

endpackage

// File: rtl/sop_cell_ctrl.sv
`timescale 1ns/1ps
module sop_cell_ctrl
  import sop_cell_pkg::*;
#(
  parameter cellKind_e CELL_KIND = CELL_INNER
) (
  input  logic [1:0]  cfgArch,
  input  logic        cfgCell,
  output cellStrobe_t strobe
);

  localparam logic IS_END = (CELL_KIND == CELL_CLK_END) || (CELL_KIND == CELL_OE_END);
  localparam logic NO_FB  = (CELL_KIND == CELL_NOFB);

  cellMode_e mode;

  always_comb begin
    unique case ({cfgArch, cfgCell})
      3'b100:  mode = M_REG;
      3'b101:  mode = M_IO_REGDEV;
      3'b111:  mode = M_IO_COMB;
      3'b010:  mode = M_OUT_COMB;
      3'b011:  mode = M_IN;
      default: mode = M_BAD;
    endcase
  end

  always_comb begin
    strobe.useReg   = 1'b0;
    strobe.dropLast = 1'b0;
    strobe.oeSrc    = OE_OFF;
    strobe.fbSrc    = FB_ZERO;
    unique case (mode)
      M_REG: begin
        strobe.useReg = 1'b1;
        strobe.oeSrc  = OE_GLOBAL;
        strobe.fbSrc  = FB_REG;
      end
      M_IO_REGDEV: begin
        strobe.dropLast = 1'b1;
        strobe.oeSrc    = OE_TERM;
        strobe.fbSrc    = FB_OWN;
      end
      M_IO_COMB: begin
        strobe.dropLast = 1'b1;
        strobe.oeSrc    = OE_TERM;
        strobe.fbSrc    = IS_END ? FB_END : FB_OWN;
      end
      M_OUT_COMB: begin
        strobe.oeSrc = OE_ON;
        if (IS_END)     strobe.fbSrc = FB_END;
        else if (NO_FB) strobe.fbSrc = FB_ZERO;
        else            strobe.fbSrc = FB_ADJ;
      end
      M_IN: begin
        strobe.oeSrc = OE_OFF;
        strobe.fbSrc = IS_END ? FB_END : FB_ADJ;
      end
      default: begin
        strobe.oeSrc = OE_OFF;
        strobe.fbSrc = FB_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/sop_cell_datapath.sv
`timescale 1ns/1ps
module sop_cell_datapath
  import sop_cell_pkg::*;
#(
  parameter int N_TERMS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  cellStrobe_t        strobe,
  input  logic [N_TERMS-1:0] termIn,
  input  logic               cfgInvert,
  input  logic               oeN,
  input  logic               pinIn,
  input  logic               adjPinIn,
  input  logic               endPinIn,
  output logic               pinOut,
  output logic               pinOe,
  output logic               fbOut
);

  localparam int OE_IDX = N_TERMS - 1;

  logic fullSum;
  logic partSum;
  logic regD;
  logic regQ;
  logic combVal;

  assign fullSum = |termIn;
  assign partSum = |termIn[OE_IDX-1:0];
  assign regD    = fullSum ^ cfgInvert;
  assign combVal = (strobe.dropLast ? partSum : fullSum) ^ cfgInvert;

  always_ff @(posedge clk) begin
    if (!rstN) regQ <= 1'b0;
    else       regQ <= regD;
  end

  assign pinOut = strobe.useReg ? regQ : combVal;

  always_comb begin
    unique case (strobe.oeSrc)
      OE_GLOBAL: pinOe = ~oeN;
      OE_TERM:   pinOe = termIn[OE_IDX];
      OE_ON:     pinOe = 1'b1;
      default:   pinOe = 1'b0;
    endcase
  end

  always_comb begin
    unique case (strobe.fbSrc)
      FB_REG:  fbOut = regQ;
      FB_OWN:  fbOut = pinIn;
      FB_ADJ:  fbOut = adjPinIn;
      FB_END:  fbOut = endPinIn;
      default: fbOut = 1'b0;
    endcase
  end

  // R1: register follows the terms and polarity present at the previous edge
  p_reg_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (regQ == ($past(|termIn) ^ $past(cfgInvert))));

  // R10: a low reset at an edge leaves the register cleared
  p_reset_clear_r10: assert property (@(posedge clk)
    !rstN |=> (regQ == 1'b0));

endmodule

// File: rtl/sop_out_cell.sv
`timescale 1ns/1ps
module sop_out_cell
  import sop_cell_pkg::*;
#(
  parameter int        N_TERMS   = 8,
  parameter cellKind_e CELL_KIND = CELL_INNER
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_TERMS-1:0] termIn,
  input  logic [1:0]         cfgArch,
  input  logic               cfgCell,
  input  logic               cfgInvert,
  input  logic               oeN,
  input  logic               pinIn,
  input  logic               adjPinIn,
  input  logic               endPinIn,
  output logic               pinOut,
  output logic               pinOe,
  output logic               fbOut
);

  localparam int OE_IDX = N_TERMS - 1;

  cellStrobe_t strobe;

  sop_cell_ctrl #(
    .CELL_KIND(CELL_KIND)
  ) uCtrl (
    .cfgArch(cfgArch),
    .cfgCell(cfgCell),
    .strobe (strobe)
  );

  sop_cell_datapath #(
    .N_TERMS(N_TERMS)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .termIn   (termIn),
    .cfgInvert(cfgInvert),
    .oeN      (oeN),
    .pinIn    (pinIn),
    .adjPinIn (adjPinIn),
    .endPinIn (endPinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .fbOut    (fbOut)
  );

  // R2: registered mode drives by the global enable and feeds back its own output
  p_reg_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgArch == 2'b10 && !cfgCell) |-> (pinOe == !oeN && fbOut == pinOut));

  // R4: I/O modes take the pin enable from the last product term
  p_io_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgArch[1] && cfgCell) |-> (pinOe == termIn[OE_IDX]));

  // R6: dedicated output always drives
  p_out_driven_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgArch == 2'b01 && !cfgCell) |-> pinOe);

  // R7: dedicated input never drives
  p_input_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgArch == 2'b01 && cfgCell) |-> !pinOe);

  // R8: register-free end cells feed back the borrowed pin
  p_end_fb_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((CELL_KIND == CELL_CLK_END || CELL_KIND == CELL_OE_END) && cfgArch[0] &&
     ({cfgArch, cfgCell} != 3'b110)) |-> (fbOut == endPinIn));

  // R9: undefined codes leave the cell quiet
  p_undef_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgArch == 2'b00 || (cfgArch == 2'b11 && !cfgCell)) |-> (!pinOe && !fbOut));

endmodule

// File: tb/sim_sop_out_cell.sv
`timescale 1ns/1ps
module sim_sop_out_cell;
  import sop_cell_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] termIn = 8'h00;
  logic [1:0] cfgArch = 2'b10;
  logic       cfgCell = 1'b0;
  logic       cfgInvert = 1'b0;
  logic       oeN = 1'b1;
  logic       pinIn = 1'b0;
  logic       adjPinIn = 1'b0;
  logic       endPinIn = 1'b0;
  logic [3:0] pOut;
  logic [3:0] pOe;
  logic [3:0] pFb;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  finished = 1'b0;
  logic refQ = 1'b0;
  bit  justReset = 1'b0;

  always #2 clk = ~clk;

  sop_out_cell #(.N_TERMS(8), .CELL_KIND(CELL_INNER)) u0 (
    .clk(clk), .rstN(rstN), .termIn(termIn), .cfgArch(cfgArch), .cfgCell(cfgCell),
    .cfgInvert(cfgInvert), .oeN(oeN), .pinIn(pinIn), .adjPinIn(adjPinIn),
    .endPinIn(endPinIn), .pinOut(pOut[0]), .pinOe(pOe[0]), .fbOut(pFb[0]));

  sop_out_cell #(.N_TERMS(8), .CELL_KIND(CELL_CLK_END)) u1 (
    .clk(clk), .rstN(rstN), .termIn(termIn), .cfgArch(cfgArch), .cfgCell(cfgCell),
    .cfgInvert(cfgInvert), .oeN(oeN), .pinIn(pinIn), .adjPinIn(adjPinIn),
    .endPinIn(endPinIn), .pinOut(pOut[1]), .pinOe(pOe[1]), .fbOut(pFb[1]));

  sop_out_cell #(.N_TERMS(8), .CELL_KIND(CELL_OE_END)) u2 (
    .clk(clk), .rstN(rstN), .termIn(termIn), .cfgArch(cfgArch), .cfgCell(cfgCell),
    .cfgInvert(cfgInvert), .oeN(oeN), .pinIn(pinIn), .adjPinIn(adjPinIn),
    .endPinIn(endPinIn), .pinOut(pOut[2]), .pinOe(pOe[2]), .fbOut(pFb[2]));

  sop_out_cell #(.N_TERMS(8), .CELL_KIND(CELL_NOFB)) u3 (
    .clk(clk), .rstN(rstN), .termIn(termIn), .cfgArch(cfgArch), .cfgCell(cfgCell),
    .cfgInvert(cfgInvert), .oeN(oeN), .pinIn(pinIn), .adjPinIn(adjPinIn),
    .endPinIn(endPinIn), .pinOut(pOut[3]), .pinOe(pOe[3]), .fbOut(pFb[3]));

  task automatic checkBit(input string tag, input string what, input int idx,
                          input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s cell%0d arch=%b cell=%b inv=%b terms=%h: got %b expected %b",
               tag, what, idx, cfgArch, cfgCell, cfgInvert, termIn, act, exp);
    end
  endtask

  // Behavioural reference: kind 0 interior, 1 clock-pin end, 2 enable-pin end, 3 no-feedback middle
  task automatic compareAll();
    for (int k = 0; k < 4; k++) begin
      logic anyAll, anyLow, eOut, eOe, eFb, outKnown, isEnd;
      string tOut, tOe, tFb;
      anyAll = 1'b0;
      anyLow = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (termIn[i]) anyAll = 1'b1;
        if (termIn[i] && i < 7) anyLow = 1'b1;
      end
      isEnd = (k == 1 || k == 2);
      outKnown = 1'b1;
      eOut = 1'b0; eOe = 1'b0; eFb = 1'b0;
      tOut = "R9"; tOe = "R9"; tFb = "R9";
      if (cfgArch == 2'b10 && !cfgCell) begin
        eOut = refQ; eOe = !oeN; eFb = refQ;
        tOut = justReset ? "R10" : "R1"; tOe = "R2"; tFb = "R2";
      end else if (cfgArch[1] && cfgCell) begin
        eOut = anyLow ^ cfgInvert; eOe = termIn[7];
        eFb = (isEnd && cfgArch[0]) ? endPinIn : pinIn;
        tOut = cfgInvert ? "R3" : "R4"; tOe = "R4";
        tFb = (isEnd && cfgArch[0]) ? "R8" : "R5";
      end else if (cfgArch == 2'b01 && !cfgCell) begin
        eOut = anyAll ^ cfgInvert; eOe = 1'b1;
        eFb = isEnd ? endPinIn : ((k == 3) ? 1'b0 : adjPinIn);
        tOut = cfgInvert ? "R3" : "R6"; tOe = "R6";
        tFb = isEnd ? "R8" : "R6";
      end else if (cfgArch == 2'b01 && cfgCell) begin
        outKnown = 1'b0;
        eOe = 1'b0; eFb = isEnd ? endPinIn : adjPinIn;
        tOe = "R7"; tFb = isEnd ? "R8" : "R7";
      end else begin
        outKnown = 1'b0;
      end
      if (outKnown) checkBit(tOut, "pinOut", k, pOut[k], eOut);
      checkBit(tOe, "pinOe", k, pOe[k], eOe);
      checkBit(tFb, "fbOut", k, pFb[k], eFb);
    end
  endtask

  task automatic runCycle(input logic [7:0] t, input logic rstVal, input logic inv);
    @(posedge clk);
    justReset = !rstN;
    if (!rstN) refQ = 1'b0;
    else       refQ = (termIn != 8'h00) ^ cfgInvert;
    #1;
    termIn    = t;
    rstN      = rstVal;
    cfgInvert = inv;
    pinIn     = 1'($urandom);
    adjPinIn  = 1'($urandom);
    endPinIn  = 1'($urandom);
    oeN       = 1'($urandom);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    logic [2:0] modeList [8];
    modeList[0] = 3'b100; modeList[1] = 3'b101; modeList[2] = 3'b111;
    modeList[3] = 3'b010; modeList[4] = 3'b011; modeList[5] = 3'b000;
    modeList[6] = 3'b110; modeList[7] = 3'b001;
    for (int m = 0; m < 8; m++) begin
      @(posedge clk);
      #1;
      {cfgArch, cfgCell} = modeList[m];
      runCycle(8'hFF, 1'b0, 1'b0);
      runCycle(8'hFF, 1'b0, 1'b1);
      for (int c = 0; c < 250; c++) begin
        logic [7:0] t;
        t = 8'($urandom & $urandom & $urandom);
        runCycle(t, (c != 120), ((c / 60) % 2) == 1);
      end
      // directed corners: enable term alone, all clear, all set, single terms
      runCycle(8'h80, 1'b1, 1'b0);
      runCycle(8'h80, 1'b1, 1'b1);
      runCycle(8'h00, 1'b1, 1'b0);
      runCycle(8'hFF, 1'b1, 1'b1);
      runCycle(8'h01, 1'b1, 1'b0);
      runCycle(8'h40, 1'b1, 1'b1);
      runCycle(8'h00, 1'b1, 1'b1);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

endmodule